// File: doc/BRIEF.md
# Serial Transmit Queue with Inter-Word Gap

This block is the transmit half of a serial port. Software pushes bytes into a 16-entry queue through a one-cycle write strobe. A serializer removes one byte at a time and sends it as an asynchronous frame on a single output line. A programmable idle gap, counted in baud ticks, can be placed in front of every byte. The gap lets the port talk to slow receivers without software pacing each byte.

The serializer takes each byte straight from the head of the queue into its shift register when the gap ends. There is no holding register between the queue and the shifter. The queue reports how many bytes it holds at all times. A run control empties it: while the control is low the queue holds nothing and accepts nothing. A level interrupt compares the fill count with a programmable threshold, and an enable gates it. Writes that reach a full queue are dropped and set a sticky overflow flag, which software clears.

Top module: `uart_tx_gapfifo`

## Requirements
- R1: The queue stores up to 16 bytes of 8 bits. `fill_count` is the number of stored bytes, from 0 to 16. An accepted write raises it by one on the following clock edge.
- R2: A write while the queue holds 16 bytes is discarded and the count stays at 16. The same edge sets `ovf_flag`, which then stays high until `ovf_clr` is asserted.
- R3: While `fifo_run` is 0, the queue is held empty (`fill_count` 0) and writes are ignored; they neither store data nor set `ovf_flag`. When `fifo_run` returns to 1, the queue starts again from empty.
- R4: Each byte goes out as one low start bit, then its 8 data bits least significant first, then one high stop bit. Every bit lasts one baud-tick period, and bit changes happen only on a clock edge where `baud_tick` is 1. The line is high whenever no frame is being sent.
- R5: With a gap setting G, the line stays high for exactly G baud-tick periods between the stop bit of one frame and the start bit of the next. With G = 0, frames follow each other back to back.
- R6: Gap settings above 256 behave as 256.
- R7: `tx_irq` is 1 exactly when `irq_en` is 1 and `fill_count` is less than or equal to `trig_level`. It follows the current count in the same cycle.
- R8: After reset, `tx_line` is 1, `fill_count` is 0 and `ovf_flag` is 0.
- R9: A byte leaves the queue on the baud-tick edge that starts its start bit. `fill_count` drops by one on that edge and `tx_line` goes low on the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| wr_data | input | 8 | Byte to queue |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| gap_len | input | 9 | Idle baud ticks placed before each byte (saturates at 256) |
| trig_level | input | 5 | Interrupt threshold on the fill count |
| irq_en | input | 1 | Interrupt enable |
| fifo_run | input | 1 | 0 holds the queue empty; 1 lets it operate |
| ovf_clr | input | 1 | Clears the overflow flag |
| tx_line | output | 1 | Serial output, idles high |
| fill_count | output | 5 | Number of bytes in the queue |
| ovf_flag | output | 1 | Sticky overflow indication |
| tx_irq | output | 1 | Fill-level interrupt |

## Verification
`fill_count` and `ovf_flag` change on the first clock edge after a write or a run change. `tx_irq` follows the count in the same cycle. The bench drives inputs and reads these outputs just after the falling edge, so every check sees the value of the last completed rising edge. The line is recorded once per bit, at the falling edge that raises `baud_tick`, just before the edge that moves to the next bit. The log therefore holds one value per bit period, and gaps and frames are decoded from it with no dependence on the clock phase inside a bit. The departure check waits for the falling edge that raises a tick and reads the count there, then reads the count and the line one cycle later.

// File: rtl/txq_pkg.sv
package txq_pkg;
    typedef enum logic [1:0] {
        SH_IDLE = 2'd0,
        SH_GAP  = 2'd1,
        SH_SEND = 2'd2
    } sh_state_e;
endpackage

// File: rtl/txq_store.sv
module txq_store #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned DEPTH  = 16,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              pop,
    output logic [DATA_W-1:0] rd_data,
    output logic [CNT_W-1:0]  fill,
    output logic              empty,
    output logic              drop
);
    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
    } qptr_t;

    qptr_t q_d, q_q;
    logic [DATA_W-1:0] mem [DEPTH];
    logic full, push, take;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        full  = (q_q.cnt == CNT_W'(DEPTH));
        push  = run && wr_en && !full;
        drop  = run && wr_en && full;
        take  = run && pop && (q_q.cnt != '0);
        q_d   = q_q;
        if (!run) begin
            q_d = '0;
        end else begin
            if (push) q_d.wr = bump(q_q.wr);
            if (take) q_d.rd = bump(q_q.rd);
            case ({push, take})
                2'b10:   q_d.cnt = q_q.cnt + 1'b1;
                2'b01:   q_d.cnt = q_q.cnt - 1'b1;
                default: q_d.cnt = q_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    always_ff @(posedge clk) begin
        if (push) mem[q_q.wr] <= wr_data;
    end

    assign rd_data = mem[q_q.rd];
    assign fill    = q_q.cnt;
    assign empty   = (q_q.cnt == '0);

    assert_fill_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CNT_W'(DEPTH));
    assert_push_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (run && wr_en && !full && !pop) |=> (fill == $past(fill) + 1'b1));
    assert_flush_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (fill == '0));
    assert_full_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && full && !pop) |=> (fill == CNT_W'(DEPTH)));
endmodule

// File: rtl/txq_serializer.sv
module txq_serializer
    import txq_pkg::*;
#(
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned GAP_W   = 9,
    parameter int unsigned GAP_MAX = 256,
    localparam int unsigned SH_W   = DATA_W + 2,
    localparam int unsigned BC_W   = $clog2(DATA_W + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic [GAP_W-1:0]  gap_len,
    input  logic              fifo_empty,
    input  logic [DATA_W-1:0] fifo_word,
    output logic              pop,
    output logic              tx
);
    typedef struct packed {
        sh_state_e        st;
        logic [GAP_W-1:0] gap_cnt;
        logic [SH_W-1:0]  shreg;
        logic [BC_W-1:0]  bits;
    } ser_t;

    ser_t s_d, s_q;
    logic [GAP_W-1:0] gap_eff;
    logic launch, load;

    always_comb begin
        gap_eff = (gap_len > GAP_W'(GAP_MAX)) ? GAP_W'(GAP_MAX) : gap_len;
        s_d    = s_q;
        launch = 1'b0;
        load   = 1'b0;
        case (s_q.st)
            SH_IDLE: if (baud_tick) launch = 1'b1;
            SH_GAP: if (baud_tick) begin
                if (fifo_empty)                   s_d.st = SH_IDLE;
                else if (s_q.gap_cnt == GAP_W'(1)) load = 1'b1;
                else                              s_d.gap_cnt = s_q.gap_cnt - 1'b1;
            end
            SH_SEND: if (baud_tick) begin
                if (s_q.bits == BC_W'(DATA_W + 1)) begin
                    launch = 1'b1;
                end else begin
                    s_d.shreg = {1'b1, s_q.shreg[SH_W-1:1]};
                    s_d.bits  = s_q.bits + 1'b1;
                end
            end
            default: s_d.st = SH_IDLE;
        endcase
        if (launch) begin
            s_d.shreg = '1;
            if (fifo_empty) begin
                s_d.st = SH_IDLE;
            end else if (gap_eff == '0) begin
                load = 1'b1;
            end else begin
                s_d.st      = SH_GAP;
                s_d.gap_cnt = gap_eff;
            end
        end
        if (load) begin
            s_d.st    = SH_SEND;
            s_d.shreg = {1'b1, fifo_word, 1'b0};
            s_d.bits  = '0;
        end
        pop = load;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st      <= SH_IDLE;
            s_q.gap_cnt <= '0;
            s_q.shreg   <= '1;
            s_q.bits    <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign tx = s_q.shreg[0];

    assert_pop_nonempty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !fifo_empty);
    assert_start_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> (tx == 1'b0));
    assert_idle_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st != SH_SEND) |-> (tx == 1'b1));
    assert_tick_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !baud_tick |=> $stable(tx));
    assert_gap_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.gap_cnt <= GAP_W'(GAP_MAX));
endmodule

// File: rtl/uart_tx_gapfifo.sv
module uart_tx_gapfifo #(
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned DEPTH   = 16,
    parameter int unsigned GAP_W   = 9,
    parameter int unsigned GAP_MAX = 256,
    localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              baud_tick,
    input  logic [GAP_W-1:0]  gap_len,
    input  logic [CNT_W-1:0]  trig_level,
    input  logic              irq_en,
    input  logic              fifo_run,
    input  logic              ovf_clr,
    output logic              tx_line,
    output logic [CNT_W-1:0]  fill_count,
    output logic              ovf_flag,
    output logic              tx_irq
);
    logic [DATA_W-1:0] head_word;
    logic              q_empty, q_drop, q_pop;
    logic              ovf_d, ovf_q;

    txq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (fifo_run),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .pop     (q_pop),
        .rd_data (head_word),
        .fill    (fill_count),
        .empty   (q_empty),
        .drop    (q_drop)
    );

    txq_serializer #(.DATA_W(DATA_W), .GAP_W(GAP_W), .GAP_MAX(GAP_MAX)) u_ser (
        .clk        (clk),
        .rst_n      (rst_n),
        .baud_tick  (baud_tick),
        .gap_len    (gap_len),
        .fifo_empty (q_empty || !fifo_run),
        .fifo_word  (head_word),
        .pop        (q_pop),
        .tx         (tx_line)
    );

    always_comb begin
        ovf_d = ovf_q;
        if (ovf_clr) ovf_d = 1'b0;
        if (q_drop)  ovf_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ovf_q <= 1'b0;
        else        ovf_q <= ovf_d;
    end

    assign ovf_flag = ovf_q;
    assign tx_irq   = irq_en && (fill_count <= trig_level);

    assert_overflow_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && fifo_run && fill_count == CNT_W'(DEPTH)) |=> ovf_flag);
    assert_overflow_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !ovf_clr) |=> ovf_flag);
    assert_off_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_run && !ovf_flag) |=> !ovf_flag);
endmodule

// File: tb/uart_tx_gapfifo_bench.sv
module uart_tx_gapfifo_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       baud_tick = 1'b0;
    logic [8:0] gap_len = '0;
    logic [4:0] trig_level = '0;
    logic       irq_en = 1'b0;
    logic       fifo_run = 1'b1;
    logic       ovf_clr = 1'b0;
    logic       tx_line;
    logic [4:0] fill_count;
    logic       ovf_flag;
    logic       tx_irq;

    int checks = 0;
    int fails  = 0;
    int div    = 0;
    logic logb [0:4095];
    int   log_n  = 0;
    logic log_on = 1'b0;
    logic [7:0] exp_bytes [0:3];

    uart_tx_gapfifo u_uart_tx_gapfifo (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .baud_tick(baud_tick), .gap_len(gap_len), .trig_level(trig_level),
        .irq_en(irq_en), .fifo_run(fifo_run), .ovf_clr(ovf_clr),
        .tx_line(tx_line), .fill_count(fill_count), .ovf_flag(ovf_flag),
        .tx_irq(tx_irq)
    );

    always #5 clk = ~clk;

    // Baud tick every 4 cycles; the line is logged just before each tick edge.
    always @(negedge clk) begin
        logic nxt;
        nxt = (div == 3);
        div = (div == 3) ? 0 : div + 1;
        if (nxt && log_on && log_n < 4096) begin
            logb[log_n] = tx_line;
            log_n++;
        end
        baud_tick <= nxt;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic push_byte(input logic [7:0] b);
        wr_en = 1'b1;
        wr_data = b;
        step();
        wr_en = 1'b0;
    endtask

    task automatic decode(input int nfr, input int gexp, input string gtag);
        int i = 0;
        while (i < log_n && logb[i] == 1'b1) i++;
        for (int k = 0; k < nfr; k++) begin
            logic [7:0] val;
            int g;
            if (i + 9 >= log_n) begin
                chk("R4 frame present", 0, 1);
                return;
            end
            chk("R4 start bit", int'(logb[i]), 0);
            for (int b = 0; b < 8; b++) val[b] = logb[i + 1 + b];
            chk("R4 data LSB first", int'(val), int'(exp_bytes[k]));
            chk("R4 stop bit", int'(logb[i + 9]), 1);
            i += 10;
            g = 0;
            while (i < log_n && logb[i] == 1'b1) begin
                g++;
                i++;
            end
            if (k < nfr - 1) chk(gtag, g, gexp);
        end
    endtask

    task automatic t_reset();
        chk("R8 line idle", int'(tx_line), 1);
        chk("R8 count zero", int'(fill_count), 0);
        chk("R8 overflow clear", int'(ovf_flag), 0);
        irq_en = 1'b1;
        trig_level = 5'd0;
        step();
        chk("R7 irq at count 0 trig 0", int'(tx_irq), 1);
    endtask

    task automatic t_fill_overflow();
        fifo_run = 1'b0;
        step();
        fifo_run = 1'b1;
        gap_len = 9'd256;
        for (int n = 0; n < 16; n++) push_byte(8'(n + 8'h10));
        chk("R1 count full", int'(fill_count), 16);
        irq_en = 1'b1;
        trig_level = 5'd16;
        step();
        chk("R7 irq count<=trig", int'(tx_irq), 1);
        trig_level = 5'd15;
        step();
        chk("R7 irq count>trig", int'(tx_irq), 0);
        push_byte(8'hEE);
        chk("R2 overflow set", int'(ovf_flag), 1);
        chk("R2 count held", int'(fill_count), 16);
        step();
        chk("R2 overflow sticky", int'(ovf_flag), 1);
        ovf_clr = 1'b1;
        step();
        ovf_clr = 1'b0;
        chk("R2 overflow cleared", int'(ovf_flag), 0);
        fifo_run = 1'b0;
        step();
        chk("R3 flush to zero", int'(fill_count), 0);
        push_byte(8'h55);
        chk("R3 write ignored count", int'(fill_count), 0);
        chk("R3 write ignored overflow", int'(ovf_flag), 0);
        fifo_run = 1'b1;
        step();
        chk("R3 resume empty", int'(fill_count), 0);
        push_byte(8'h66);
        chk("R3 resume accepts", int'(fill_count), 1);
        irq_en = 1'b0;
        trig_level = 5'd16;
        step();
        chk("R7 irq disabled", int'(tx_irq), 0);
        fifo_run = 1'b0;
        repeat (12) step();
        fifo_run = 1'b1;
        chk("R4 line idle after flush", int'(tx_line), 1);
    endtask

    task automatic t_direct_load();
        int guard = 0;
        gap_len = 9'd0;
        push_byte(8'h77);
        while (baud_tick != 1'b1 && guard < 8) begin
            step();
            guard++;
        end
        chk("R9 held until tick", int'(fill_count), 1);
        chk("R9 line high before start", int'(tx_line), 1);
        step();
        chk("R9 count drops at start", int'(fill_count), 0);
        chk("R9 start bit on same edge", int'(tx_line), 0);
        repeat (60) step();
    endtask

    task automatic t_frames(input int nfr, input int gset, input int gexp, input string gtag);
        gap_len = 9'(gset);
        log_n = 0;
        log_on = 1'b1;
        for (int k = 0; k < nfr; k++) push_byte(exp_bytes[k]);
        repeat ((nfr * (10 + gexp) + gexp + 8) * 4 + 20) step();
        log_on = 1'b0;
        chk("R1 drained", int'(fill_count), 0);
        decode(nfr, gexp, gtag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", fails, checks);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_fill_overflow();
        t_direct_load();
        exp_bytes[0] = 8'hA5; exp_bytes[1] = 8'h3C; exp_bytes[2] = 8'h01;
        t_frames(3, 0, 0, "R5 back-to-back gap");
        exp_bytes[0] = 8'h80; exp_bytes[1] = 8'hFF;
        t_frames(2, 5, 5, "R5 gap of five");
        exp_bytes[0] = 8'h5A; exp_bytes[1] = 8'hC3;
        t_frames(2, 300, 256, "R6 gap saturates at 256");
        $display("Result: errors=%0d of %0d checks", fails, checks);
        $finish;
    end
endmodule